// File: doc/BRIEF.md
# Serial EEPROM Transaction Host

This block is a serial-bus master that turns single parallel requests into complete exchanges with a byte-addressed serial EEPROM. A host presents a command (read or write, a 13-bit start address and a byte count) on a valid/ready pair. The block then drives chip select, the serial clock and the outgoing data line. It samples the incoming data line and returns read bytes on a strobed output. Write data is pulled from a stream input one byte per handshake.

For a write, the block splits the request into page-sized pieces of at most 32 bytes, with each piece kept inside one page. Each piece takes three steps. First comes a short enable transaction of its own, closed by raising chip select. Next comes the write transaction itself. Last, the block polls the status byte until its write-in-progress bit clears. A read is one long transaction: the block keeps clocking after the address and the device's pointer advances, wrapping from the top of the 8 KiB space to zero. The serial clock is the system clock divided by a parameter, in mode 0 (clock idles low, data sampled on the rising edge), most significant bit first.

The controller is a 14-state machine. The states are IDLE, WREN, WR_OP, WR_AH, WR_AL, WR_DATA, POLL_OP, POLL_VAL, RD_OP, RD_AH, RD_AL, RD_DATA, GAP and FINISH.
- IDLE moves to WREN on a write, to RD_OP on a read, or to FINISH on a zero count.
- Each byte state advances when its byte completes. WR_DATA and RD_DATA repeat until their count runs out.
- Every transaction ends in GAP, which holds chip select high for one serial clock period. GAP then jumps to a stored return state:
  - WR_OP after an enable;
  - POLL_OP after a write piece or while the device is still busy;
  - WREN when bytes remain;
  - FINISH otherwise.
- FINISH pulses done and returns to IDLE.

Top module: `spi_eeprom_host`

## Requirements
- R1: The serial clock is low whenever chip select is high. The outgoing data line never changes while the serial clock is high, nor in the cycle the clock rises (mode 0).
- R2: A read of N bytes is one transaction made of three parts, in this order:
  - the opcode 0x03;
  - a 16-bit address sent most significant bit first, whose top three bits are zero;
  - 8*N further clocks.
- R3: Read bytes appear on rd_data with one rd_valid pulse each, in ascending address order, with the address wrapping from 0x1FFF to 0x0000.
- R4: Every write piece is preceded by its own transaction that carries only the opcode 0x06 (8 clocks) and is closed by chip select rising. The write opcode 0x02 follows in a new transaction.
- R5: A write transaction carries the opcode 0x02, the 16-bit address, then min(remaining, 32 - address[4:0]) data bytes, so no transaction crosses a 32-byte page. The address advances across pages and wraps at 0x1FFF.
- R6: Chip select rises only after a whole number of bytes (a multiple of 8 clocks) since it fell.
- R7: After each write transaction the block repeats transactions of opcode 0x05 plus one status byte until bit 0 of the status byte is 0. Only then does it issue the next enable or finish, and no read is issued while a write is in progress.
- R8: Chip select stays high for at least 2*HALF_DIV system cycles (one serial clock period) between transactions.
- R9: cmd_ready is high only in the idle state. busy is high from the cycle after acceptance until done has pulsed for one cycle, and low in the cycle after done.
- R10: A command with a byte count of 0 completes with a done pulse and produces no chip select activity.
- R11: Within a byte, successive rising edges of the serial clock are exactly 2*HALF_DIV system cycles apart.
- R12: Write data is taken one byte per wr_valid/wr_ready handshake, in order. wr_ready rises only while chip select is low in a write data phase, and exactly the requested count is consumed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_valid | input | 1 | Command request |
| cmd_ready | output | 1 | Command accepted when high with cmd_valid |
| cmd_write | input | 1 | 1 for write, 0 for read |
| cmd_addr | input | ADDR_W (13) | Start byte address |
| cmd_len | input | LEN_W (16) | Byte count |
| wr_data | input | 8 | Write data byte |
| wr_valid | input | 1 | Write data available |
| wr_ready | output | 1 | Write data byte taken |
| rd_data | output | 8 | Read data byte |
| rd_valid | output | 1 | One-cycle strobe for rd_data |
| busy | output | 1 | Command in progress |
| done | output | 1 | One-cycle completion pulse |
| spi_cs_n | output | 1 | Chip select, active low |
| spi_sclk | output | 1 | Serial clock |
| spi_mosi | output | 1 | Serial data to the device |
| spi_miso | input | 1 | Serial data from the device |

## Verification
Faults in the state machine show up on the bus within one transaction. Two examples:
- A lost return state shows as a wrong opcode or a missing status poll in the very next frame.
- A bad page-span computation shows as a write frame whose length runs past the page end.

Counter faults show up in different ways:
- A divider or bit counter slip changes the clock period or leaves a frame with a clock count that is not a multiple of eight, which is visible when chip select rises.
- A wrong address register shows within the first returned byte, because the bench model serves data derived from the address it decoded.

The write data path is only exposed after a read-back, one command later.

// File: rtl/spi_eeprom_pkg.sv
package spi_eeprom_pkg;
    timeunit 1ns;
    timeprecision 1ps;

    localparam logic [7:0] OP_READ  = 8'h03;
    localparam logic [7:0] OP_WRITE = 8'h02;
    localparam logic [7:0] OP_WREN  = 8'h06;
    localparam logic [7:0] OP_RDSR  = 8'h05;

    typedef enum logic [3:0] {
        S_IDLE,
        S_WREN,
        S_WR_OP,
        S_WR_AH,
        S_WR_AL,
        S_WR_DATA,
        S_POLL_OP,
        S_POLL_VAL,
        S_RD_OP,
        S_RD_AH,
        S_RD_AL,
        S_RD_DATA,
        S_GAP,
        S_FINISH
    } host_state_t;
endpackage

// File: rtl/spi_byte_shifter.sv
module spi_byte_shifter #(
    parameter int HALF_DIV = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       start,
    input  logic [7:0] tx_byte,
    input  logic       miso,
    output logic       busy,
    output logic       done,
    output logic       sclk,
    output logic       mosi,
    output logic [7:0] rx_byte
);
    timeunit 1ns;
    timeprecision 1ps;

    localparam int CW = (HALF_DIV > 1) ? $clog2(HALF_DIV) : 1;
    localparam logic [CW-1:0] DIV_LAST = CW'(HALF_DIV - 1);

    logic [CW-1:0] div_q;
    logic [2:0]    bit_q;
    logic [7:0]    sh_q;
    logic [7:0]    rx_q;
    logic          act_q;
    logic          sclk_q;
    logic          done_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            div_q  <= '0;
            bit_q  <= '0;
            sh_q   <= '0;
            rx_q   <= '0;
            act_q  <= 1'b0;
            sclk_q <= 1'b0;
            done_q <= 1'b0;
        end else begin
            done_q <= 1'b0;
            if (!act_q) begin
                if (start) begin
                    act_q <= 1'b1;
                    sh_q  <= tx_byte;
                    bit_q <= '0;
                    div_q <= '0;
                end
            end else if (div_q == DIV_LAST) begin
                div_q <= '0;
                if (!sclk_q) begin
                    sclk_q <= 1'b1;
                    rx_q   <= {rx_q[6:0], miso};
                end else begin
                    sclk_q <= 1'b0;
                    sh_q   <= {sh_q[6:0], 1'b0};
                    bit_q  <= bit_q + 3'd1;
                    if (bit_q == 3'd7) begin
                        act_q  <= 1'b0;
                        done_q <= 1'b1;
                    end
                end
            end else begin
                div_q <= div_q + CW'(1);
            end
        end
    end

    assign busy    = act_q;
    assign done    = done_q;
    assign sclk    = sclk_q;
    assign mosi    = act_q ? sh_q[7] : 1'b0;
    assign rx_byte = rx_q;
endmodule

// File: rtl/spi_page_span.sv
module spi_page_span #(
    parameter int LEN_W      = 16,
    parameter int PAGE_BYTES = 32,
    localparam int PW        = $clog2(PAGE_BYTES)
) (
    input  logic [PW-1:0]    offset,
    input  logic [LEN_W-1:0] remain,
    output logic [LEN_W-1:0] chunk
);
    timeunit 1ns;
    timeprecision 1ps;

    logic [LEN_W-1:0] room;

    always_comb begin
        room  = LEN_W'(PAGE_BYTES) - LEN_W'(offset);
        chunk = (remain < room) ? remain : room;
    end
endmodule

// File: rtl/spi_eeprom_host.sv
module spi_eeprom_host
    import spi_eeprom_pkg::*;
#(
    parameter int ADDR_W     = 13,
    parameter int LEN_W      = 16,
    parameter int HALF_DIV   = 2,
    parameter int PAGE_BYTES = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cmd_valid,
    output logic              cmd_ready,
    input  logic              cmd_write,
    input  logic [ADDR_W-1:0] cmd_addr,
    input  logic [LEN_W-1:0]  cmd_len,
    input  logic [7:0]        wr_data,
    input  logic              wr_valid,
    output logic              wr_ready,
    output logic [7:0]        rd_data,
    output logic              rd_valid,
    output logic              busy,
    output logic              done,
    output logic              spi_cs_n,
    output logic              spi_sclk,
    output logic              spi_mosi,
    input  logic              spi_miso
);
    timeunit 1ns;
    timeprecision 1ps;

    localparam int GAP_CYC = 2 * HALF_DIV;
    localparam int GW      = $clog2(GAP_CYC + 1);
    localparam int PW      = $clog2(PAGE_BYTES);
    localparam logic [GW-1:0] GAP_LAST = GW'(GAP_CYC - 1);

    host_state_t       state_q, state_d;
    host_state_t       ret_q, ret_d;
    logic [ADDR_W-1:0] addr_q;
    logic [LEN_W-1:0]  rem_q;
    logic [LEN_W-1:0]  chunk_q;
    logic [LEN_W-1:0]  span;
    logic [GW-1:0]     gap_q;
    logic              issued_q;

    logic       byte_state;
    logic [7:0] tx_byte;
    logic [15:0] addr_frame;
    logic       eng_start, eng_busy, eng_done;
    logic [7:0] eng_rx;

    assign addr_frame = 16'(addr_q);

    spi_byte_shifter #(.HALF_DIV(HALF_DIV)) u_shift (
        .clk     (clk),
        .rst_n   (rst_n),
        .start   (eng_start),
        .tx_byte (tx_byte),
        .miso    (spi_miso),
        .busy    (eng_busy),
        .done    (eng_done),
        .sclk    (spi_sclk),
        .mosi    (spi_mosi),
        .rx_byte (eng_rx)
    );

    spi_page_span #(.LEN_W(LEN_W), .PAGE_BYTES(PAGE_BYTES)) u_span (
        .offset (addr_q[PW-1:0]),
        .remain (rem_q),
        .chunk  (span)
    );

    // byte selection and engine launch
    always_comb begin
        byte_state = 1'b1;
        tx_byte    = 8'h00;
        unique case (state_q)
            S_WREN:     tx_byte = OP_WREN;
            S_WR_OP:    tx_byte = OP_WRITE;
            S_RD_OP:    tx_byte = OP_READ;
            S_POLL_OP:  tx_byte = OP_RDSR;
            S_WR_AH,
            S_RD_AH:    tx_byte = addr_frame[15:8];
            S_WR_AL,
            S_RD_AL:    tx_byte = addr_frame[7:0];
            S_WR_DATA:  tx_byte = wr_data;
            S_POLL_VAL,
            S_RD_DATA:  tx_byte = 8'h00;
            default:    byte_state = 1'b0;
        endcase
        wr_ready  = (state_q == S_WR_DATA) && !issued_q && !eng_busy;
        eng_start = byte_state && !issued_q && !eng_busy &&
                    ((state_q != S_WR_DATA) || wr_valid);
    end

    // next-state logic
    always_comb begin
        state_d = state_q;
        ret_d   = ret_q;
        unique case (state_q)
            S_IDLE: begin
                if (cmd_valid) begin
                    if (cmd_len == '0)  state_d = S_FINISH;
                    else if (cmd_write) state_d = S_WREN;
                    else                state_d = S_RD_OP;
                end
            end
            S_WREN: begin
                if (eng_done) begin
                    state_d = S_GAP;
                    ret_d   = S_WR_OP;
                end
            end
            S_WR_OP:   if (eng_done) state_d = S_WR_AH;
            S_WR_AH:   if (eng_done) state_d = S_WR_AL;
            S_WR_AL:   if (eng_done) state_d = S_WR_DATA;
            S_WR_DATA: begin
                if (eng_done && chunk_q == LEN_W'(1)) begin
                    state_d = S_GAP;
                    ret_d   = S_POLL_OP;
                end
            end
            S_POLL_OP: if (eng_done) state_d = S_POLL_VAL;
            S_POLL_VAL: begin
                if (eng_done) begin
                    state_d = S_GAP;
                    if (eng_rx[0])          ret_d = S_POLL_OP;
                    else if (rem_q == '0)   ret_d = S_FINISH;
                    else                    ret_d = S_WREN;
                end
            end
            S_RD_OP:   if (eng_done) state_d = S_RD_AH;
            S_RD_AH:   if (eng_done) state_d = S_RD_AL;
            S_RD_AL:   if (eng_done) state_d = S_RD_DATA;
            S_RD_DATA: begin
                if (eng_done && rem_q == LEN_W'(1)) begin
                    state_d = S_GAP;
                    ret_d   = S_FINISH;
                end
            end
            S_GAP:     if (gap_q == GAP_LAST) state_d = ret_q;
            S_FINISH:  state_d = S_IDLE;
            default:   state_d = S_IDLE;
        endcase
    end

    // state register and datapath
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q  <= S_IDLE;
            ret_q    <= S_IDLE;
            addr_q   <= '0;
            rem_q    <= '0;
            chunk_q  <= '0;
            gap_q    <= '0;
            issued_q <= 1'b0;
        end else begin
            state_q <= state_d;
            ret_q   <= ret_d;
            if (eng_done)       issued_q <= 1'b0;
            else if (eng_start) issued_q <= 1'b1;
            gap_q <= (state_q == S_GAP) ? gap_q + GW'(1) : '0;
            if (state_q == S_IDLE && cmd_valid) begin
                addr_q <= cmd_addr;
                rem_q  <= cmd_len;
            end
            if (state_q == S_WR_OP && eng_start)
                chunk_q <= span;
            if (eng_done && (state_q == S_WR_DATA || state_q == S_RD_DATA)) begin
                addr_q <= addr_q + ADDR_W'(1);
                rem_q  <= rem_q - LEN_W'(1);
            end
            if (eng_done && state_q == S_WR_DATA)
                chunk_q <= chunk_q - LEN_W'(1);
        end
    end

    // outputs
    always_comb begin
        spi_cs_n  = !byte_state;
        cmd_ready = (state_q == S_IDLE);
        busy      = (state_q != S_IDLE);
        done      = (state_q == S_FINISH);
        rd_valid  = eng_done && (state_q == S_RD_DATA);
        rd_data   = eng_rx;
    end
endmodule

// File: rtl/spi_eeprom_host_chk.sv
module spi_eeprom_host_chk #(
    parameter int HALF_DIV = 2
) (
    input logic clk,
    input logic rst_n,
    input logic cmd_valid,
    input logic cmd_ready,
    input logic busy,
    input logic done,
    input logic wr_valid,
    input logic wr_ready,
    input logic rd_valid,
    input logic spi_cs_n,
    input logic spi_sclk,
    input logic spi_mosi
);
    timeunit 1ns;
    timeprecision 1ps;

    localparam int GAP_CYC = 2 * HALF_DIV;
    localparam int HW      = $clog2(GAP_CYC + 1);

    logic [HW-1:0] hi_cnt;
    logic [2:0]    edge_cnt;
    logic          sclk_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            hi_cnt   <= HW'(GAP_CYC);
            edge_cnt <= '0;
            sclk_d   <= 1'b0;
        end else begin
            sclk_d <= spi_sclk;
            if (!spi_cs_n)                      hi_cnt <= '0;
            else if (hi_cnt != HW'(GAP_CYC))    hi_cnt <= hi_cnt + HW'(1);
            if (spi_cs_n)                       edge_cnt <= '0;
            else if (spi_sclk && !sclk_d)       edge_cnt <= edge_cnt + 3'd1;
        end
    end

    p_sclk_idle_r1: assert property (@(posedge clk) disable iff (!rst_n)
        spi_cs_n |-> !spi_sclk);
    p_mosi_hold_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (spi_sclk && sclk_d) |-> $stable(spi_mosi));
    p_mosi_setup_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (spi_sclk && !sclk_d) |-> $stable(spi_mosi));
    p_whole_bytes_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(spi_cs_n) |-> (edge_cnt == 3'd0));
    p_cs_gap_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(spi_cs_n) |-> (hi_cnt >= HW'(GAP_CYC)));
    p_busy_accept_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && cmd_ready) |=> busy);
    p_ready_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_ready |-> !busy);
    p_done_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> (!done && !busy));
    p_wr_framed_r12: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_valid && wr_ready) |-> !spi_cs_n);
    p_rd_framed_r3: assert property (@(posedge clk) disable iff (!rst_n)
        rd_valid |-> !spi_cs_n);
endmodule

bind spi_eeprom_host spi_eeprom_host_chk #(.HALF_DIV(HALF_DIV)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .cmd_valid (cmd_valid),
    .cmd_ready (cmd_ready),
    .busy      (busy),
    .done      (done),
    .wr_valid  (wr_valid),
    .wr_ready  (wr_ready),
    .rd_valid  (rd_valid),
    .spi_cs_n  (spi_cs_n),
    .spi_sclk  (spi_sclk),
    .spi_mosi  (spi_mosi)
);

// File: tb/spi_eeprom_host_bench.sv
module spi_eeprom_host_bench;
    timeunit 1ns;
    timeprecision 1ps;

    localparam int HALF = 2;
    localparam int PER  = 2 * HALF;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cmd_valid = 1'b0, cmd_ready, cmd_write = 1'b0;
    logic [12:0] cmd_addr = '0;
    logic [15:0] cmd_len = '0;
    logic [7:0]  wr_data = '0;
    logic        wr_valid = 1'b0, wr_ready;
    logic [7:0]  rd_data;
    logic        rd_valid, busy, done;
    logic        spi_cs_n, spi_sclk, spi_mosi;
    logic        spi_miso = 1'b0;

    always #2 clk = ~clk;

    spi_eeprom_host u_spi_eeprom_host (
        .clk(clk), .rst_n(rst_n),
        .cmd_valid(cmd_valid), .cmd_ready(cmd_ready), .cmd_write(cmd_write),
        .cmd_addr(cmd_addr), .cmd_len(cmd_len),
        .wr_data(wr_data), .wr_valid(wr_valid), .wr_ready(wr_ready),
        .rd_data(rd_data), .rd_valid(rd_valid), .busy(busy), .done(done),
        .spi_cs_n(spi_cs_n), .spi_sclk(spi_sclk), .spi_mosi(spi_mosi),
        .spi_miso(spi_miso)
    );

    int checks = 0;
    int failures = 0;
    int cyc = 0;
    always @(posedge clk) cyc++;

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    // ---------------- device model ----------------
    logic [7:0]  mem [256];
    logic [7:0]  dbytes [64];
    logic [7:0]  log_op [64];
    int          log_bits [64];
    logic [15:0] log_addr [64];
    int          log_dlen [64];
    int          ntr = 0;
    int          dn = 0;
    int          bitc = 0;
    logic [7:0]  in_sh = '0, op = '0, out_next = '0, out_cur = '0;
    logic [15:0] maddr = '0, cur_addr = '0;
    bit          in_tr = 0, wel = 0, wip = 0;
    int          wip_left = 0, wr_no_wel = 0, rd_in_wip = 0;
    int          rise_cyc = 0, last_pos = -1;
    int          min_gap = 1000000, min_per = 1000000;

    task automatic model_byte(input int k, input logic [7:0] b);
        if (k == 0) begin
            op = b;
            out_next = (b == 8'h05) ? {6'b0, wel, wip} : 8'h00;
        end else if (op == 8'h05) begin
            out_next = {6'b0, wel, wip};
        end else if (op == 8'h03 || op == 8'h02) begin
            if (k == 1) maddr[15:8] = b;
            else if (k == 2) begin
                maddr[7:0] = b;
                cur_addr = maddr;
                out_next = mem[maddr[7:0]];
            end else if (op == 8'h03) begin
                maddr = (maddr + 16'd1) & 16'h1FFF;
                out_next = mem[maddr[7:0]];
            end else begin
                if (dn < 64) dbytes[dn] = b;
                dn++;
            end
        end
    endtask

    always @(negedge spi_cs_n) begin
        if (rst_n) begin
            in_tr = 1; bitc = 0; dn = 0; out_next = 8'h00; last_pos = -1;
            cur_addr = '0;
            if (cyc - rise_cyc < min_gap) min_gap = cyc - rise_cyc;
        end
    end

    always @(posedge spi_sclk) begin
        if (in_tr) begin
            if (last_pos >= 0 && (cyc - last_pos) < min_per) min_per = cyc - last_pos;
            last_pos = cyc;
            in_sh = {in_sh[6:0], spi_mosi};
            bitc++;
            if (bitc % 8 == 0) model_byte(bitc / 8 - 1, in_sh);
        end
    end

    always @(negedge spi_sclk) begin
        if (in_tr) begin
            if (bitc % 8 == 0) out_cur = out_next;
            spi_miso = out_cur[7];
            out_cur = {out_cur[6:0], 1'b0};
        end
    end

    always @(posedge spi_cs_n) begin
        if (in_tr) begin
            in_tr = 0;
            rise_cyc = cyc;
            if (ntr < 64) begin
                log_op[ntr]   = op;
                log_bits[ntr] = bitc;
                log_addr[ntr] = cur_addr;
                log_dlen[ntr] = (bitc / 8) - 3;
            end
            ntr++;
            if (op == 8'h06 && bitc == 8) wel = 1;
            if (op == 8'h03 && wip) rd_in_wip++;
            if (op == 8'h05 && wip) begin
                wip_left--;
                if (wip_left == 0) wip = 0;
            end
            if (op == 8'h02 && bitc % 8 == 0 && bitc >= 32) begin
                if (!wel) wr_no_wel++;
                else begin
                    for (int i = 0; i < dn && i < 64; i++) begin
                        logic [15:0] pa;
                        pa = (cur_addr & 16'hFFE0) | ((cur_addr + 16'(i)) & 16'h001F);
                        mem[pa[7:0]] = dbytes[i];
                    end
                    wel = 0; wip = 1; wip_left = 2;
                end
            end
        end
    end

    // ---------------- host-side streams ----------------
    logic [7:0] wbuf [64];
    logic [7:0] rbuf [64];
    int widx = 0, wlen = 0, rn = 0;
    bit take = 0;

    always @(negedge clk) begin
        if (take) widx++;
        wr_valid = (widx < wlen);
        wr_data  = (widx < wlen) ? wbuf[widx] : 8'h00;
        take     = wr_valid && wr_ready;
        if (rd_valid === 1'b1) begin
            if (rn < 64) rbuf[rn] = rd_data;
            rn++;
        end
    end

    task automatic run_cmd(input bit wr, input logic [12:0] a, input int n);
        int guard;
        @(negedge clk);
        cmd_write = wr; cmd_addr = a; cmd_len = 16'(n); cmd_valid = 1'b1;
        while (!cmd_ready) @(negedge clk);
        @(negedge clk);
        cmd_valid = 1'b0;
        chk(busy == 1'b1, "R9", "busy after accept", int'(busy), 1);
        guard = 0;
        while (!done && guard < 40000) begin
            @(negedge clk);
            guard++;
        end
        chk(done == 1'b1, "R9", "done pulse seen", int'(done), 1);
        @(negedge clk);
        chk(busy == 1'b0, "R9", "busy after done", int'(busy), 0);
    endtask

    task automatic chk_piece(input int idx, input logic [15:0] a, input int n);
        chk(log_op[idx] == 8'h06 && log_bits[idx] == 8, "R4",
            "enable frame", int'(log_op[idx]), 8'h06);
        chk(log_op[idx+1] == 8'h02, "R4", "write opcode after enable",
            int'(log_op[idx+1]), 8'h02);
        chk(log_addr[idx+1] == a, "R5", "write piece address", int'(log_addr[idx+1]), int'(a));
        chk(log_dlen[idx+1] == n, "R5", "write piece length", log_dlen[idx+1], n);
        for (int j = 2; j < 5; j++)
            chk(log_op[idx+j] == 8'h05 && log_bits[idx+j] == 16, "R7",
                "status poll frame", int'(log_op[idx+j]), 8'h05);
    endtask

    // ---------------- scenarios ----------------
    task automatic t_reset();
        chk(spi_cs_n == 1'b1, "R1", "cs idle high", int'(spi_cs_n), 1);
        chk(spi_sclk == 1'b0, "R1", "sclk idle low", int'(spi_sclk), 0);
        chk(busy == 1'b0, "R9", "busy at reset", int'(busy), 0);
        chk(cmd_ready == 1'b1, "R9", "ready at reset", int'(cmd_ready), 1);
    endtask

    task automatic t_read_basic();
        int n0 = ntr;
        rn = 0;
        run_cmd(0, 13'h0010, 4);
        chk(ntr - n0 == 1, "R2", "single read frame", ntr - n0, 1);
        chk(log_op[n0] == 8'h03, "R2", "read opcode", int'(log_op[n0]), 8'h03);
        chk(log_addr[n0] == 16'h0010, "R2", "read address", int'(log_addr[n0]), 16'h0010);
        chk(log_bits[n0] == 56, "R2", "read clock count", log_bits[n0], 56);
        chk(rn == 4, "R3", "read strobes", rn, 4);
        for (int i = 0; i < 4; i++)
            chk(rbuf[i] == (8'(16 + i) ^ 8'h5A), "R3", "read byte",
                int'(rbuf[i]), int'(8'(16 + i) ^ 8'h5A));
    endtask

    task automatic t_read_wrap();
        int n0 = ntr;
        logic [7:0] e [3];
        e[0] = 8'hFE ^ 8'h5A; e[1] = 8'hFF ^ 8'h5A; e[2] = 8'h00 ^ 8'h5A;
        rn = 0;
        run_cmd(0, 13'h1FFE, 3);
        chk(log_addr[n0] == 16'h1FFE, "R2", "top address bits zero",
            int'(log_addr[n0]), 16'h1FFE);
        chk(rn == 3, "R3", "wrap strobes", rn, 3);
        for (int i = 0; i < 3; i++)
            chk(rbuf[i] == e[i], "R3", "wrap byte", int'(rbuf[i]), int'(e[i]));
    endtask

    task automatic t_zero_len();
        int n0 = ntr;
        run_cmd(1, 13'h0020, 0);
        chk(ntr == n0, "R10", "no frame for zero count", ntr - n0, 0);
    endtask

    task automatic t_write(input logic [12:0] a, input int n,
                           input int npieces, input logic [15:0] pa [3], input int pn [3]);
        int n0 = ntr;
        for (int i = 0; i < n; i++) wbuf[i] = 8'(8'hC3 + 8'(7 * i) + 8'(a));
        widx = 0; wlen = n;
        run_cmd(1, a, n);
        chk(widx == n, "R12", "bytes consumed", widx, n);
        chk(ntr - n0 == 5 * npieces, "R7", "frame count", ntr - n0, 5 * npieces);
        for (int p = 0; p < npieces; p++) chk_piece(n0 + 5 * p, pa[p], pn[p]);
        chk(wr_no_wel == 0, "R4", "write without enable", wr_no_wel, 0);
        wlen = 0; widx = 0;
        rn = 0;
        run_cmd(0, a, n);
        chk(rd_in_wip == 0, "R7", "read during write cycle", rd_in_wip, 0);
        for (int i = 0; i < n; i++)
            chk(rbuf[i] == wbuf[i], "R12", "read-back byte", int'(rbuf[i]), int'(wbuf[i]));
    endtask

    task automatic t_timing();
        int bad = 0;
        for (int i = 0; i < ntr && i < 64; i++) if (log_bits[i] % 8 != 0) bad++;
        chk(bad == 0, "R6", "frames of whole bytes", bad, 0);
        chk(min_gap >= PER, "R8", "cs high gap", min_gap, PER);
        chk(min_per == PER, "R11", "sclk period", min_per, PER);
    endtask

    task automatic finish_run();
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        checks++;
        failures++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        logic [15:0] pa [3];
        int pn [3];
        for (int i = 0; i < 256; i++) mem[i] = 8'(i) ^ 8'h5A;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_read_basic();
        t_read_wrap();
        t_zero_len();
        pa[0] = 16'h0040; pn[0] = 5; pa[1] = 0; pn[1] = 0; pa[2] = 0; pn[2] = 0;
        t_write(13'h0040, 5, 1, pa, pn);
        pa[0] = 16'h005C; pn[0] = 4; pa[1] = 16'h0060; pn[1] = 32; pa[2] = 16'h0080; pn[2] = 4;
        t_write(13'h005C, 40, 3, pa, pn);
        pa[0] = 16'h1FFC; pn[0] = 4; pa[1] = 16'h0000; pn[1] = 2; pa[2] = 0; pn[2] = 0;
        t_write(13'h1FFC, 6, 2, pa, pn);
        t_timing();
        finish_run();
    end
endmodule